// File: doc/BRIEF.md
# Ping-Pong Descriptor Transfer Engine

This block is a single-channel transfer engine. It copies elements from a source region to a destination region, one element per clock. Two descriptors held in registers control it: a primary one and an alternate one. Each descriptor stores the address of the last source element, the address of the last destination element, and a control word. The engine works out every element address backwards from those end addresses, using a countdown of the elements still to move.

Software writes the descriptors and a command word through a small register-write port. A cycle begins on the primary descriptor unless the alternate-select flag is set. An auto cycle runs to completion after a software request. Basic and ping-pong cycles move an element only in clocks where the request input is high. In ping-pong operation the engine flips to the other descriptor each time one finishes. Software can refresh the finished descriptor while the other one runs. The chain ends when a basic descriptor completes. It halts when the next descriptor has been left invalid.

Top module: `pp_dma_engine`

## Requirements
- R1: After reset the channel is disabled (`chan_en` low), `done` is low and no memory read or write is issued.
- R2: Control-word cycle code 2 (auto) moves count+1 elements, one per clock, after command bit 4 (software request) and command bit 0 (enable set). The request input plays no part. The count is field [17:8].
- R3: The element k of N is read at src_end − ((N−1−k) << src_inc) and written at dst_end − ((N−1−k) << dst_inc). The increment codes 0, 1 and 2 (fields [5:4] source, [7:6] destination) give the shift. Code 3 keeps the address fixed at the end address.
- R4: Size code 0, 1 or 2 (field [3:2]) writes 1, 2 or 4 bytes per element, taken from the low bits of the read data. Bytes outside the element are left unchanged.
- R5: Under cycle code 1 (basic) or 3 (ping-pong), an element moves only in a clock where `req_i` is high. A low request stalls the cycle with no memory access.
- R6: One clock after the final element of a descriptor, `done` is high for exactly one clock. `done_alt` is 0 for the primary descriptor and 1 for the alternate. A finishing auto or basic descriptor clears `chan_en`.
- R7: Register 6 bit 2 sets the alternate-select flag and bit 3 clears it. An enabled cycle starts on the alternate descriptor only while the flag is set.
- R8: When a ping-pong descriptor finishes, the engine pulses `done` and continues on the other descriptor.
- R9: If the descriptor being switched to has cycle code 0 (invalid), the channel clears `chan_en` without moving any element and without a further `done`.
- R10: A basic descriptor reached through a ping-pong chain ends the chain when it finishes, even if the other descriptor is valid again.
- R11: A finished descriptor has its cycle code written back to invalid. Re-enabling it without rewriting the control word disables the channel with no transfer and no `done`.
- R12: Command bit 1 (enable clear) stops a cycle part way through. No later element moves and no `done` is raised.
- R13: A count field of 1023 moves 1024 elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0/1/2 primary src end, dst end, control; 3/4/5 alternate; 6 command |
| cfg_wdata | input | 32 | Register write data |
| req_i | input | 1 | Peripheral request for basic and ping-pong cycles |
| rd_en | output | 1 | Memory read strobe, one per element |
| rd_addr | output | AW | Element source address |
| rd_data | input | 32 | Read data, element right-aligned, same clock |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Element destination address |
| wr_data | output | 32 | Write data, element right-aligned |
| wr_size | output | 2 | Element size code: 0 byte, 1 half-word, 2 word |
| chan_en | output | 1 | Channel enable flag |
| done | output | 1 | One-clock completion pulse |
| done_alt | output | 1 | Which descriptor finished with the last pulse |

## Verification
The hardest state to reach from the ports is a ping-pong chain that ends because a basic descriptor completes, not because the next descriptor is invalid. To show this, the bench holds the request low as soon as the first `done` appears. It then rewrites the primary control word to a valid ping-pong code and releases the request. Only the basic rule can then stop the channel. Descriptor write-back is observed the same way: the bench re-enables a completed descriptor untouched and watches that no element moves. A mid-cycle disable is reached by gating the request for an exact number of clocks.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int CNT_W = 10;

  typedef enum logic [1:0] {
    CYC_STOP  = 2'd0,
    CYC_BASIC = 2'd1,
    CYC_AUTO  = 2'd2,
    CYC_PING  = 2'd3
  } cyc_e;

  // control word, bit 0 upward: cycle, size, src inc, dst inc, count-1
  typedef struct packed {
    logic [CNT_W-1:0] n_m1;
    logic [1:0]       dst_inc;
    logic [1:0]       src_inc;
    logic [1:0]       size;
    cyc_e             cyc;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [2:0] REG_SRC = 3'd0;
  localparam logic [2:0] REG_DST = 3'd1;
  localparam logic [2:0] REG_CTL = 3'd2;
  localparam logic [2:0] REG_CMD = 3'd6;

  localparam int CMD_EN_SET  = 0;
  localparam int CMD_EN_CLR  = 1;
  localparam int CMD_ALT_SET = 2;
  localparam int CMD_ALT_CLR = 3;
  localparam int CMD_SWREQ   = 4;
  localparam int CMD_W       = 5;
endpackage

// File: rtl/pp_desc_bank.sv
module pp_desc_bank
  import pp_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [2:0]            cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic                  retire,
  input  logic                  retire_alt,
  output logic [1:0][AW-1:0]    src_end,
  output logic [1:0][AW-1:0]    dst_end,
  output ctrl_t [1:0]           ctrl
);
  for (genvar d = 0; d < 2; d++) begin : g_desc
    localparam logic [2:0] A_SRC = 3'(3 * d) + REG_SRC;
    localparam logic [2:0] A_DST = 3'(3 * d) + REG_DST;
    localparam logic [2:0] A_CTL = 3'(3 * d) + REG_CTL;

    logic [AW-1:0] src_q, src_d, dst_q, dst_d;
    ctrl_t         ctl_q, ctl_d;

    always_comb begin
      src_d = src_q;
      dst_d = dst_q;
      ctl_d = ctl_q;
      if (retire && (retire_alt == 1'(d))) ctl_d.cyc = CYC_STOP;
      if (cfg_we && cfg_addr == A_SRC) src_d = cfg_wdata[AW-1:0];
      if (cfg_we && cfg_addr == A_DST) dst_d = cfg_wdata[AW-1:0];
      if (cfg_we && cfg_addr == A_CTL) ctl_d = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q <= '0;
        dst_q <= '0;
        ctl_q <= '0;
      end else begin
        src_q <= src_d;
        dst_q <= dst_d;
        ctl_q <= ctl_d;
      end
    end

    assign src_end[d] = src_q;
    assign dst_end[d] = dst_q;
    assign ctrl[d]    = ctl_q;

    // R11
    writeback_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(retire) && ($past(retire_alt) == 1'(d)) &&
       !($past(cfg_we) && ($past(cfg_addr) == A_CTL))) |-> (ctl_q.cyc == CYC_STOP));
  end
endmodule

// File: rtl/pp_addr_gen.sv
module pp_addr_gen
  import pp_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    end_addr,
  input  logic [1:0]       inc,
  input  logic [CNT_W-1:0] rem,
  output logic [AW-1:0]    addr
);
  localparam logic [1:0] INC_NONE = 2'd3;

  always_comb begin
    if (inc == INC_NONE) addr = end_addr;
    else                 addr = end_addr - (AW'(rem) << inc);
  end
endmodule

// File: rtl/pp_sequencer.sv
module pp_sequencer
  import pp_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd,
  input  logic             req_i,
  input  cyc_e             cur_cyc,
  input  logic [CNT_W-1:0] cur_n,
  output logic             sel,
  output logic [CNT_W-1:0] rem,
  output logic             xfer,
  output logic             retire,
  output logic             chan_en,
  output logic             done,
  output logic             done_alt
);
  logic             en_q, en_d, sel_q, sel_d, ld_q, ld_d, go_q, go_d;
  logic             done_q, done_d, dalt_q, dalt_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             step;

  assign step   = (cur_cyc == CYC_AUTO) ? go_q : req_i;
  assign xfer   = en_q && ld_q && step;
  assign retire = xfer && (rem_q == '0);

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    ld_d   = ld_q;
    go_d   = go_q;
    rem_d  = rem_q;
    done_d = 1'b0;
    dalt_d = dalt_q;
    if (en_q) begin
      if (!ld_q) begin
        if (cur_cyc == CYC_STOP) begin
          en_d = 1'b0;
        end else begin
          rem_d = cur_n;
          ld_d  = 1'b1;
        end
      end else if (retire) begin
        done_d = 1'b1;
        dalt_d = sel_q;
        ld_d   = 1'b0;
        go_d   = 1'b0;
        if (cur_cyc == CYC_PING) sel_d = ~sel_q;
        else                     en_d  = 1'b0;
      end else if (xfer) begin
        rem_d = rem_q - 1'b1;
      end
    end
    if (cmd_we) begin
      if (cmd[CMD_SWREQ])   go_d  = 1'b1;
      if (cmd[CMD_ALT_SET]) sel_d = 1'b1;
      if (cmd[CMD_ALT_CLR]) sel_d = 1'b0;
      if (cmd[CMD_EN_SET])  en_d  = 1'b1;
      if (cmd[CMD_EN_CLR]) begin
        en_d = 1'b0;
        ld_d = 1'b0;
        go_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
      ld_q   <= 1'b0;
      go_q   <= 1'b0;
      rem_q  <= '0;
      done_q <= 1'b0;
      dalt_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      sel_q  <= sel_d;
      ld_q   <= ld_d;
      go_q   <= go_d;
      rem_q  <= rem_d;
      done_q <= done_d;
      dalt_q <= dalt_d;
    end
  end

  assign sel      = sel_q;
  assign rem      = rem_q;
  assign chan_en  = en_q;
  assign done     = done_q;
  assign done_alt = dalt_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  ping_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retire) && ($past(cur_cyc) == CYC_PING) && !$past(cmd_we)) |-> (sel_q != $past(sel_q)));

  // R10
  basic_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(retire) && ($past(cur_cyc) == CYC_BASIC) && !$past(cmd_we)) |-> !en_q);
endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
  import pp_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_i,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic [1:0]    wr_size,
  output logic          chan_en,
  output logic          done,
  output logic          done_alt
);
  logic [1:0][AW-1:0] src_end, dst_end;
  ctrl_t [1:0]        ctrl;
  ctrl_t              cur;
  logic               sel, xfer, retire;
  logic [CNT_W-1:0]   rem;
  logic [1:0][AW-1:0] gen_end;
  logic [1:0][1:0]    gen_inc;
  logic [1:0][AW-1:0] gen_addr;

  pp_desc_bank #(.AW(AW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .retire     (retire),
    .retire_alt (sel),
    .src_end    (src_end),
    .dst_end    (dst_end),
    .ctrl       (ctrl)
  );

  assign cur = ctrl[sel];

  pp_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_we   (cfg_we && (cfg_addr == REG_CMD)),
    .cmd      (cfg_wdata[CMD_W-1:0]),
    .req_i    (req_i),
    .cur_cyc  (cur.cyc),
    .cur_n    (cur.n_m1),
    .sel      (sel),
    .rem      (rem),
    .xfer     (xfer),
    .retire   (retire),
    .chan_en  (chan_en),
    .done     (done),
    .done_alt (done_alt)
  );

  assign gen_end[0] = src_end[sel];
  assign gen_end[1] = dst_end[sel];
  assign gen_inc[0] = cur.src_inc;
  assign gen_inc[1] = cur.dst_inc;

  for (genvar g = 0; g < 2; g++) begin : g_addr
    pp_addr_gen #(.AW(AW)) u_agen (
      .end_addr (gen_end[g]),
      .inc      (gen_inc[g]),
      .rem      (rem),
      .addr     (gen_addr[g])
    );
  end

  assign rd_en   = xfer;
  assign wr_en   = xfer;
  assign rd_addr = gen_addr[0];
  assign wr_addr = gen_addr[1];
  assign wr_data = rd_data;
  assign wr_size = cur.size;

  // R5
  req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (cur.cyc != CYC_AUTO)) |-> req_i);

  // R6
  done_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_en));
endmodule

// File: tb/test_pp_dma_engine.sv
module test_pp_dma_engine;
  logic        clk, rst_n, cfg_we, req_i;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, rd_data, wr_data;
  logic        rd_en, wr_en, chan_en, done_o, done_alt_o;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  wr_size;

  int total = 0, bad = 0;
  int xfer_cnt = 0, done_cnt = 0;
  logic [31:0] rd_log [32];
  logic [31:0] wr_log [32];
  logic        done_log [4];
  logic [7:0]  mem [1024];

  localparam logic [31:0] C_EN = 32'd1, C_DIS = 32'd2, C_ASET = 32'd4, C_ACLR = 32'd8, C_SW = 32'd16;

  pp_dma_engine i_pp_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_i(req_i), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size), .chan_en(chan_en),
    .done(done_o), .done_alt(done_alt_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [31:0] mk_ctl(input int n, input int di, input int si, input int sz, input int cy);
    return {14'd0, 10'(n), 2'(di), 2'(si), 2'(sz), 2'(cy)};
  endfunction

  always_comb begin
    rd_data = {mem[10'(rd_addr[9:0] + 10'd3)], mem[10'(rd_addr[9:0] + 10'd2)],
               mem[10'(rd_addr[9:0] + 10'd1)], mem[rd_addr[9:0]]};
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else begin
      if (wr_en)
        for (int k = 0; k < 4; k++)
          if (k < (1 << wr_size)) mem[10'(wr_addr[9:0] + 10'(k))] <= wr_data[8*k +: 8];
      if (rd_en) begin
        if (xfer_cnt < 32) begin
          rd_log[xfer_cnt] = rd_addr;
          wr_log[xfer_cnt] = wr_addr;
        end
        xfer_cnt++;
      end
      if (done_o) begin
        done_log[done_cnt % 4] = done_alt_o;
        done_cnt++;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr();
    xfer_cnt = 0;
    done_cnt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 chan_en", 32'(chan_en), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 rd_en", 32'(rd_en), 0);
  endtask

  task automatic t_auto();
    clr();
    wr_reg(3'd0, 32'h10C); wr_reg(3'd1, 32'h20C);
    wr_reg(3'd2, mk_ctl(3, 2, 2, 2, 2));
    wr_reg(3'd6, C_EN | C_SW);
    idle(10);
    chk("R2 count", 32'(xfer_cnt), 4);
    chk("R3 first rd", rd_log[0], 32'h100);
    chk("R3 last rd", rd_log[3], 32'h10C);
    chk("R3 wr1", wr_log[1], 32'h204);
    chk("R4 word", {mem[10'h207], mem[10'h206], mem[10'h205], mem[10'h204]},
        {pat('h107), pat('h106), pat('h105), pat('h104)});
    chk("R6 done count", 32'(done_cnt), 1);
    chk("R6 done_alt", 32'(done_log[0]), 0);
    chk("R6 en cleared", 32'(chan_en), 0);
  endtask

  task automatic t_sizes();
    clr();
    wr_reg(3'd0, 32'h302); wr_reg(3'd1, 32'h380);
    wr_reg(3'd2, mk_ctl(2, 3, 0, 0, 2));
    wr_reg(3'd6, C_EN | C_SW);
    idle(8);
    chk("R3 byte step", rd_log[1], 32'h301);
    chk("R3 fixed dst", wr_log[2], 32'h380);
    chk("R4 byte data", 32'(mem[10'h380]), 32'(pat('h302)));
    chk("R4 byte neighbour", 32'(mem[10'h381]), 32'(pat('h381)));
    clr();
    wr_reg(3'd0, 32'h312); wr_reg(3'd1, 32'h392);
    wr_reg(3'd2, mk_ctl(1, 1, 1, 1, 2));
    wr_reg(3'd6, C_EN | C_SW);
    idle(8);
    chk("R3 half step", wr_log[0], 32'h390);
    chk("R4 half data", {mem[10'h393], mem[10'h392], mem[10'h391], mem[10'h390]},
        {pat('h313), pat('h312), pat('h311), pat('h310)});
    chk("R4 half neighbour", 32'(mem[10'h394]), 32'(pat('h394)));
  endtask

  task automatic t_basic_req();
    clr();
    wr_reg(3'd0, 32'h008); wr_reg(3'd1, 32'h2C8);
    wr_reg(3'd2, mk_ctl(2, 2, 2, 2, 1));
    wr_reg(3'd6, C_EN);
    idle(6);
    chk("R5 stalled", 32'(xfer_cnt), 0);
    chk("R5 still enabled", 32'(chan_en), 1);
    req_i = 1'b1; idle(1); req_i = 1'b0; idle(3);
    chk("R5 single step", 32'(xfer_cnt), 1);
    req_i = 1'b1; idle(6); req_i = 1'b0;
    chk("R5 complete", 32'(xfer_cnt), 3);
    chk("R6 basic en cleared", 32'(chan_en), 0);
  endtask

  task automatic t_alt();
    clr();
    wr_reg(3'd6, C_ASET);
    wr_reg(3'd3, 32'h144); wr_reg(3'd4, 32'h244);
    wr_reg(3'd5, mk_ctl(1, 2, 2, 2, 2));
    wr_reg(3'd6, C_EN | C_SW);
    idle(8);
    chk("R7 alt source", rd_log[0], 32'h140);
    chk("R7 alt count", 32'(xfer_cnt), 2);
    chk("R6 done_alt alt", 32'(done_log[0]), 1);
    wr_reg(3'd6, C_ACLR);
  endtask

  task automatic t_ping();
    clr();
    wr_reg(3'd0, 32'h004); wr_reg(3'd1, 32'h284);
    wr_reg(3'd2, mk_ctl(1, 2, 2, 2, 3));
    wr_reg(3'd3, 32'h028); wr_reg(3'd4, 32'h2A8);
    wr_reg(3'd5, mk_ctl(2, 2, 2, 2, 3));
    req_i = 1'b1;
    wr_reg(3'd6, C_EN);
    idle(20);
    req_i = 1'b0;
    chk("R8 total elements", 32'(xfer_cnt), 5);
    chk("R8 switch address", rd_log[2], 32'h020);
    chk("R8 done pulses", 32'(done_cnt), 2);
    chk("R8 first done primary", 32'(done_log[0]), 0);
    chk("R8 second done alt", 32'(done_log[1]), 1);
    chk("R9 halted on invalid", 32'(chan_en), 0);
  endtask

  task automatic t_ping_halt();
    clr();
    wr_reg(3'd6, C_ACLR);
    wr_reg(3'd5, 32'd0);
    wr_reg(3'd2, mk_ctl(1, 2, 2, 2, 3));
    req_i = 1'b1;
    wr_reg(3'd6, C_EN);
    idle(12);
    req_i = 1'b0;
    chk("R9 elements", 32'(xfer_cnt), 2);
    chk("R9 one done", 32'(done_cnt), 1);
    chk("R9 en low", 32'(chan_en), 0);
  endtask

  task automatic t_basic_end();
    clr();
    wr_reg(3'd6, C_ACLR);
    wr_reg(3'd2, mk_ctl(1, 2, 2, 2, 3));
    wr_reg(3'd5, mk_ctl(1, 2, 2, 2, 1));
    req_i = 1'b1;
    wr_reg(3'd6, C_EN);
    for (int i = 0; i < 50 && !done_o; i++) @(negedge clk);
    req_i = 1'b0;
    wr_reg(3'd2, mk_ctl(1, 2, 2, 2, 3));
    req_i = 1'b1;
    idle(15);
    req_i = 1'b0;
    chk("R10 elements", 32'(xfer_cnt), 4);
    chk("R10 done count", 32'(done_cnt), 2);
    chk("R10 last done alt", 32'(done_log[1]), 1);
    chk("R10 chain ended", 32'(chan_en), 0);
  endtask

  task automatic t_writeback();
    clr();
    wr_reg(3'd6, C_ACLR);
    wr_reg(3'd0, 32'h004); wr_reg(3'd1, 32'h2E4);
    wr_reg(3'd2, mk_ctl(1, 2, 2, 2, 2));
    wr_reg(3'd6, C_EN | C_SW);
    idle(8);
    chk("R11 first run", 32'(xfer_cnt), 2);
    clr();
    wr_reg(3'd6, C_EN | C_SW);
    idle(8);
    chk("R11 no rerun", 32'(xfer_cnt), 0);
    chk("R11 no done", 32'(done_cnt), 0);
    chk("R11 en low", 32'(chan_en), 0);
  endtask

  task automatic t_disable();
    clr();
    wr_reg(3'd0, 32'h01C); wr_reg(3'd1, 32'h2DC);
    wr_reg(3'd2, mk_ctl(7, 2, 2, 2, 1));
    wr_reg(3'd6, C_EN);
    idle(3);
    req_i = 1'b1; idle(2); req_i = 1'b0;
    wr_reg(3'd6, C_DIS);
    req_i = 1'b1; idle(8); req_i = 1'b0;
    chk("R12 partial", 32'(xfer_cnt), 2);
    chk("R12 no done", 32'(done_cnt), 0);
    chk("R12 en low", 32'(chan_en), 0);
  endtask

  task automatic t_max();
    clr();
    wr_reg(3'd0, 32'h050); wr_reg(3'd1, 32'h3F0);
    wr_reg(3'd2, mk_ctl(1023, 3, 3, 0, 2));
    wr_reg(3'd6, C_EN | C_SW);
    idle(1100);
    chk("R13 count", 32'(xfer_cnt), 1024);
    chk("R13 done", 32'(done_cnt), 1);
    chk("R13 fixed src", rd_log[31], 32'h050);
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; req_i = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_auto();
    t_sizes();
    t_basic_req();
    t_alt();
    t_ping();
    t_ping_halt();
    t_basic_end();
    t_writeback();
    t_disable();
    t_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule